// File: doc/BRIEF.md
# Four-Channel DAC Register Front End over SPI

This block is the serial register front end of a four-channel digital-to-analog converter. A host talks to it over a plain SPI link in mode 0, one 24-bit word per chip-select window, most significant bit first. Each completed word is decoded either as a write or as a read request. A write targets one of a channel's code, gain, offset or clear registers. A control write instead carries a 3-bit sub-register selector in its top data bits.

A read request does not answer in its own window. The addressed 16-bit value is captured when the read word completes and is shifted out on MISO during the next chip-select window. The host normally fills that window with the harmless word 0x1CE000. If the host sends any other word in that window, the word is executed normally while the captured value leaves the shifter. Reads use their own address map. That map also exposes a status input and two global control registers. The stored channel codes are driven out in parallel for the converter core. The analog side is not part of this block.

Top module: `dacreg_spi_top`

## Requirements
- R1: A frame is the span while `spi_cs_n` is low. MOSI is sampled on rising SCLK edges and MISO advances on falling edges, most significant bit first. Bit 23 is the read flag, bits 20:16 are the address and bits 15:0 are the data.
- R2: A frame that ends with any bit count other than 24 is dropped. It changes no register and leaves any pending readback value in place.
- R3: A write (bit 23 clear) to address n stores a channel code, 0x08+n stores gain, 0x10+n stores offset and 0x14+n stores the clear code, for channel n in 0..3. A write to any other address below 0x1C changes nothing.
- R4: A write to 0x1C+n is a control write. Data bits 15:13 select the target: 0 is the per-channel slew register, 1 the global main register, 2 the per-channel output control register and 3 the global converter-supply register. Each target stores data bits 12:0. Selectors 4 to 7 store nothing, so 0x1CE000 has no effect.
- R5: A read request (bit 23 set) changes no register. The value addressed at the end of that frame appears on bits 15:0 of the MISO word in the next frame, and bits 23:16 of that word are zero.
- R6: The read map is: code n, output control 0x04+n, gain 0x08+n, offset 0x0C+n, clear 0x10+n, slew 0x14+n, `status_in` 0x18, main 0x19 and converter-supply 0x1A. 13-bit registers are zero-extended, and every other read address returns zero.
- R7: A non-no-op word sent in the frame after a read is executed normally, while that frame still shifts out the pending readback value.
- R8: A frame that follows a completed non-read frame shifts out all zeros.
- R9: After reset every register, the pending readback value and `spi_miso` are zero.
- R10: `dac_code` presents the four channel codes, channel n in bits 16n+15:16n. It changes only when a completed code write lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI pins are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| status_in | input | 16 | Status word returned at read address 0x18 |
| dac_code | output | 64 | Four 16-bit channel codes, channel 0 in the low bits |

## Verification
On every cycle, the assertions check that a decoded frame is a single pulse while chip select is high. They also check that the upper byte of each MISO word is zero at load, that a non-read frame clears the pending value, and that the channel codes only move when a frame lands and never on a read. Only the bench's scenarios can show the full register map: the address decoding in both directions, the sub-register selectors, the one-frame delay of readback, a readback that overlaps a write, and frames dropped for a wrong bit count with the pending value kept across them.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int FRAME_BITS = 24;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int PAY_W      = 13;
  localparam int RD_FLAG    = 23;
  localparam int ADDR_LSB   = 16;

  // write-side groups: address bits 4:2
  localparam logic [2:0] WG_CODE = 3'd0;
  localparam logic [2:0] WG_GAIN = 3'd2;
  localparam logic [2:0] WG_OFFS = 3'd4;
  localparam logic [2:0] WG_CLR  = 3'd5;
  localparam logic [2:0] WG_CTRL = 3'd7;

  // read-side groups: address bits 4:2
  localparam logic [2:0] RG_CODE = 3'd0;
  localparam logic [2:0] RG_OCTL = 3'd1;
  localparam logic [2:0] RG_GAIN = 3'd2;
  localparam logic [2:0] RG_OFFS = 3'd3;
  localparam logic [2:0] RG_CLR  = 3'd4;
  localparam logic [2:0] RG_SLEW = 3'd5;
  localparam logic [2:0] RG_GLOB = 3'd6;

  typedef enum logic [2:0] {
    SUB_SLEW = 3'd0,
    SUB_MAIN = 3'd1,
    SUB_OCTL = 3'd2,
    SUB_SUPP = 3'd3,
    SUB_SOFT = 3'd4
  } ctl_sel_e;
endpackage

// File: rtl/dacreg_spi_link.sv
module dacreg_spi_link #(
  parameter int FRAME_BITS = 24,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  input  logic [DATA_W-1:0]     load_word,
  output logic                  frame_vld,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_BITS-1:0] rx_sr, tx_sr;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign sclk_fall = ~sclk_s[1] & sclk_s[2];
  assign cs_rise   = cs_s[1] & ~cs_s[2];
  assign cs_fall   = ~cs_s[1] & cs_s[2];
  assign active    = ~cs_s[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      if (cs_fall) begin
        bit_cnt <= '0;
        tx_sr   <= FRAME_BITS'(load_word);
      end else begin
        if (active && sclk_rise) begin
          rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s[1]};
          if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
        if (active && sclk_fall) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
      end
      frame_vld <= cs_rise && (bit_cnt == CNT_FULL);
      if (cs_rise) frame_word <= rx_sr;
    end
  end

  assign spi_miso = tx_sr[FRAME_BITS-1];

  // R2: a completed frame is reported while the select is inactive
  a_r2_vld_cs_high: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> cs_s[1]);
  // R2: one decode pulse per frame
  a_r2_vld_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld);
  // R5: the upper byte of a freshly loaded readback word is zero
  a_r5_tx_upper_zero: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (tx_sr[FRAME_BITS-1:DATA_W] == '0));
endmodule

// File: rtl/dacreg_bank.sv
module dacreg_bank
  import dacreg_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_vld,
  input  logic [FRAME_BITS-1:0] frame_word,
  input  logic [DATA_W-1:0]     status_in,
  output logic [DATA_W-1:0]     pend_word,
  output logic [NCH*DATA_W-1:0] dac_code
);
  logic [DATA_W-1:0] code_q [NCH];
  logic [DATA_W-1:0] gain_q [NCH];
  logic [DATA_W-1:0] offs_q [NCH];
  logic [DATA_W-1:0] clr_q  [NCH];
  logic [PAY_W-1:0]  slew_q [NCH];
  logic [PAY_W-1:0]  octl_q [NCH];
  logic [PAY_W-1:0]  main_q, supp_q;
  logic [DATA_W-1:0] pend_q, rd_val;

  logic              is_rd, ch_ok;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        grp;
  logic [1:0]        ch;
  logic [DATA_W-1:0] wdata;
  ctl_sel_e          sel;

  assign is_rd = frame_word[RD_FLAG];
  assign addr  = frame_word[ADDR_LSB +: ADDR_W];
  assign grp   = addr[4:2];
  assign ch    = addr[1:0];
  assign ch_ok = int'(ch) < NCH;
  assign wdata = frame_word[DATA_W-1:0];
  assign sel   = ctl_sel_e'(wdata[DATA_W-1 -: 3]);

  always_comb begin
    rd_val = '0;
    case (grp)
      RG_CODE: if (ch_ok) rd_val = code_q[ch];
      RG_OCTL: if (ch_ok) rd_val = DATA_W'(octl_q[ch]);
      RG_GAIN: if (ch_ok) rd_val = gain_q[ch];
      RG_OFFS: if (ch_ok) rd_val = offs_q[ch];
      RG_CLR:  if (ch_ok) rd_val = clr_q[ch];
      RG_SLEW: if (ch_ok) rd_val = DATA_W'(slew_q[ch]);
      RG_GLOB: begin
        case (ch)
          2'd0:    rd_val = status_in;
          2'd1:    rd_val = DATA_W'(main_q);
          2'd2:    rd_val = DATA_W'(supp_q);
          default: rd_val = '0;
        endcase
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        code_q[c] <= '0;
        gain_q[c] <= '0;
        offs_q[c] <= '0;
        clr_q[c]  <= '0;
        slew_q[c] <= '0;
        octl_q[c] <= '0;
      end
      main_q <= '0;
      supp_q <= '0;
      pend_q <= '0;
    end else if (frame_vld) begin
      if (is_rd) begin
        pend_q <= rd_val;
      end else begin
        pend_q <= '0;
        if (ch_ok) begin
          case (grp)
            WG_CODE: code_q[ch] <= wdata;
            WG_GAIN: gain_q[ch] <= wdata;
            WG_OFFS: offs_q[ch] <= wdata;
            WG_CLR:  clr_q[ch]  <= wdata;
            WG_CTRL: begin
              case (sel)
                SUB_SLEW: slew_q[ch] <= wdata[PAY_W-1:0];
                SUB_MAIN: main_q     <= wdata[PAY_W-1:0];
                SUB_OCTL: octl_q[ch] <= wdata[PAY_W-1:0];
                SUB_SUPP: supp_q     <= wdata[PAY_W-1:0];
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign pend_word = pend_q;

  for (genvar c = 0; c < NCH; c++) begin : g_code
    assign dac_code[c*DATA_W +: DATA_W] = code_q[c];
  end

  // R10: codes move only on a decoded frame
  a_r10_code_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> $stable(dac_code));
  // R5: a read request leaves the codes untouched
  a_r5_read_no_write: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && frame_word[RD_FLAG]) |=> $stable(dac_code));
  // R8: a non-read frame leaves nothing pending
  a_r8_pend_cleared: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !frame_word[RD_FLAG]) |=> (pend_word == '0));
endmodule

// File: rtl/dacreg_spi_top.sv
module dacreg_spi_top
  import dacreg_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  input  logic [DATA_W-1:0]     status_in,
  output logic [NCH*DATA_W-1:0] dac_code
);
  logic                  frame_vld;
  logic [FRAME_BITS-1:0] frame_word;
  logic [DATA_W-1:0]     pend_word;

  dacreg_spi_link #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_link (
    .clk        (clk),
    .rst        (rst),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .load_word  (pend_word),
    .frame_vld  (frame_vld),
    .frame_word (frame_word)
  );

  dacreg_bank #(.NCH(NCH)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .frame_vld  (frame_vld),
    .frame_word (frame_word),
    .status_in  (status_in),
    .pend_word  (pend_word),
    .dac_code   (dac_code)
  );
endmodule

// File: tb/tb_dacreg_spi_top.sv
`timescale 1ns/1ps
module tb_dacreg_spi_top;
  localparam logic [23:0] NOOP = 24'h1CE000;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [15:0] status_in = 16'hA5C3;
  logic [63:0] dac_code;

  always #2 clk = ~clk;  // 250 MHz

  dacreg_spi_top dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .status_in(status_in),
    .dac_code(dac_code)
  );

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0;

  // behavioural reference state
  logic [15:0] md[4], mg[4], mo[4], mc[4];
  logic [12:0] ms[4], mk[4];
  logic [12:0] mmain = '0, msupp = '0;
  logic [15:0] m_pend = '0;
  logic [63:0] model_code;

  always_comb for (int i = 0; i < 4; i++) model_code[i*16 +: 16] = md[i];

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mread(input int a);
    if (a < 4)       return md[a];
    else if (a < 8)  return {3'b0, mk[a-4]};
    else if (a < 12) return mg[a-8];
    else if (a < 16) return mo[a-12];
    else if (a < 20) return mc[a-16];
    else if (a < 24) return {3'b0, ms[a-20]};
    else if (a == 24) return status_in;
    else if (a == 25) return {3'b0, mmain};
    else if (a == 26) return {3'b0, msupp};
    return 16'h0;
  endfunction

  task automatic apply(input logic [23:0] w);
    int a;
    logic [15:0] d;
    a = int'(w[20:16]);
    d = w[15:0];
    if (w[23]) begin
      m_pend = mread(a);
    end else begin
      m_pend = '0;
      if (a < 4) md[a] = d;
      else if (a >= 8 && a < 12) mg[a-8] = d;
      else if (a >= 16 && a < 20) mo[a-16] = d;
      else if (a >= 20 && a < 24) mc[a-20] = d;
      else if (a >= 28) begin
        if (d[15:13] == 3'd0) ms[a-28] = d[12:0];
        else if (d[15:13] == 3'd1) mmain = d[12:0];
        else if (d[15:13] == 3'd2) mk[a-28] = d[12:0];
        else if (d[15:13] == 3'd3) msupp = d[12:0];
      end
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
    got = '0;
    spi_cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 24) ? w[23-i] : 1'b0;
      wclk(8);
      if (i < 24) got = {got[22:0], spi_miso};
      spi_sclk = 1'b1;
      wclk(8);
      spi_sclk = 1'b0;
    end
    wclk(8);
    cmp_en = 0;
    spi_cs_n = 1'b1;
    wclk(12);
  endtask

  task automatic op(input logic [23:0] w, input string tag);
    logic [23:0] got, exp;
    exp = {8'h00, m_pend};
    xfer(w, 24, got);
    check(got === exp, tag, 64'(got), 64'(exp));
    apply(w);
    cmp_en = 1;
  endtask

  task automatic short_frame(input logic [23:0] w, input int n);
    logic [23:0] got;
    xfer(w, n, got);
    cmp_en = 1;
  endtask

  function automatic logic [23:0] wr(input int a, input logic [15:0] d);
    return {3'b000, 5'(a), d};
  endfunction
  function automatic logic [23:0] rd(input int a);
    return {3'b100, 5'(a), 16'h0};
  endfunction
  function automatic logic [23:0] ctl(input int c, input int s, input logic [12:0] p);
    return {3'b000, 5'(28 + c), 3'(s), p};
  endfunction

  // R10: code outputs follow the model on every clock
  always @(negedge clk) begin
    if (cmp_en && !rst && !done) begin
      checks++;
      if (dac_code !== model_code) begin
        fails++;
        $display("FAIL R10 dac_code: got %h expected %h", dac_code, model_code);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      md[i] = '0; mg[i] = '0; mo[i] = '0; mc[i] = '0; ms[i] = '0; mk[i] = '0;
    end
    wclk(6);
    rst = 1'b0;
    wclk(4);
    check(spi_miso === 1'b0, "R9 miso after reset", 64'(spi_miso), 64'd0);
    check(dac_code === 64'h0, "R9 codes after reset", dac_code, 64'h0);
    cmp_en = 1;

    // R1 / R3 code writes
    op(wr(0, 16'h1234), "R9 first frame shifts zero");
    op(wr(1, 16'hABCD), "R1 write ch1");
    op(wr(2, 16'h8001), "R1 write ch2");
    op(wr(3, 16'hFFFF), "R3 write ch3");
    op(rd(2), "R8 zero after write");
    op(NOOP, "R5 code ch2 readback");

    // gain / offset / clear
    op(wr(5'h09, 16'h5A5A), "R8 zero after read+noop");
    op(wr(5'h12, 16'h0F0F), "R3 offset write");
    op(wr(5'h17, 16'hC3C3), "R3 clear write");
    op(rd(5'h09), "R8 before gain read");
    op(rd(5'h0E), "R6 gain ch1");
    op(rd(5'h13), "R6 offset ch2");
    op(NOOP, "R6 clear ch3");

    // control sub-registers
    op(ctl(1, 0, 13'h1ABC), "R4 slew write");
    op(ctl(2, 2, 13'h0123), "R4 output control write");
    op(ctl(3, 1, 13'h0055), "R4 main write");
    op(ctl(0, 3, 13'h0077), "R4 supply write");
    op(ctl(0, 4, 13'h1FFF), "R4 selector 4 stores nothing");
    op(ctl(2, 5, 13'h1555), "R4 selector 5 stores nothing");
    op(rd(5'h15), "R4 before slew read");
    op(rd(5'h06), "R4 slew ch1 readback");
    op(rd(5'h19), "R4 output control ch2 readback");
    op(rd(5'h1A), "R4 main readback");
    op(rd(5'h18), "R4 supply readback");
    op(rd(5'h1B), "R6 status readback");
    op(NOOP, "R6 unmapped read zero");

    // unmapped writes ignored
    op(wr(5'h05, 16'hDEAD), "R3 unmapped write");
    op(wr(5'h0C, 16'hBEEF), "R3 unmapped write");
    op(wr(5'h18, 16'hCAFE), "R3 unmapped write");
    op(rd(5'h0C), "R3 before offset ch0 read");
    op(rd(5'h04), "R3 offset ch0 untouched");
    op(NOOP, "R3 output control ch0 untouched");

    // R7 overlapped readback and write
    op(rd(1), "R7 before read");
    op(wr(1, 16'h7777), "R7 readback during write");
    op(rd(1), "R7 zero after write");
    op(NOOP, "R7 write took effect");

    // R2 dropped frames keep pending value
    op(rd(3), "R2 before read");
    short_frame(wr(0, 16'h0BAD), 23);
    short_frame(wr(0, 16'h0BAD), 25);
    op(NOOP, "R2 pending kept across dropped frames");

    // status follows its input
    status_in = 16'h0F1E;
    op(rd(5'h18), "R6 before status read");
    op(NOOP, "R6 status changed");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule